// File: doc/BRIEF.md
# Watchdog Timer with Timed-Access Guard

This block watches for a stalled program. A divider counts every clock from a known start. When the divider reaches the interval chosen by a two-bit select input, a timeout flag goes up. The flag can raise an interrupt. If the reset enable is set and software does not restart the divider within a fixed grace period after the flag, the block drives a system reset pulse of fixed length. It also records that the reset came from the watchdog.

The two control bits that matter most are the restart bit and the reset enable. Both are guarded. Software must first write a two-byte key to a separate key register: 0xAA, then 0x55 within a few machine cycles. That opens a short write window. A write to a guarded bit outside the window is dropped. Machine-cycle timing comes from a tick input that pulses once per machine cycle. The timeout, the grace period and the pulse length are counted in clocks.

Two state machines hold the behaviour. The key machine has the states KEY_IDLE, KEY_WAIT and KEY_OPEN:
- KEY_IDLE to KEY_WAIT: on a key write of 0xAA.
- KEY_WAIT to KEY_OPEN: on a key write of 0x55.
- KEY_WAIT back to KEY_WAIT: on a further write of 0xAA, which starts the wait again.
- KEY_WAIT to KEY_IDLE: on any other key write, or on wait expiry.
- KEY_OPEN to KEY_WAIT: on a key write of 0xAA.
- KEY_OPEN to KEY_IDLE: on any other key write, on window expiry, or on a watchdog reset.

The reset machine has the states DOG_RUN, DOG_ARMED and DOG_BITE:
- DOG_RUN to DOG_ARMED: on a timeout while the reset enable is set.
- DOG_ARMED to DOG_RUN: on an accepted restart.
- DOG_ARMED to DOG_BITE: when the grace count runs out.
- DOG_BITE to DOG_RUN: when the pulse count ends.

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` is asserted, the following are all 0: reset enable, timeout flag, reset-cause flag, `wd_rst` and `wd_irq`.
- R2: The timeout flag rises exactly 2^(TAP_BASE + tmo_sel*TAP_STEP) clocks after the divider was last cleared. `tmo_sel` is 0 to 3. The defaults give 2^17, 2^20, 2^23 and 2^26 clocks.
- R3: Control bit 0 is the restart. When written with 1 while the window is open, it clears the divider for that one cycle only and is not stored. Written with the window closed, it has no effect.
- R4: Writing 0 to control bit 2 clears the timeout flag. Writing 1 leaves the flag as it is, and a timeout in the same cycle wins over the clear. `wd_irq` is high exactly while the flag, `wd_ie` and `glb_ie` are all 1.
- R5: Control bit 1 is the reset enable, and it is guarded. With the reset enable at 1, `wd_rst` rises RST_DELAY clocks after the timeout flag rises (default 512). The reset does not happen if an accepted restart comes first. The reset never occurs with the enable at 0.
- R6: `wd_rst` stays high for RST_CLKS clocks (default 8). On entry to the reset, the reset-cause flag (control bit 3, cleared by writing 0) is set and the timeout flag is cleared. The reset enable keeps its value. The divider restarts when the pulse ends.
- R7: Writing 0xAA to the key register starts a wait of TA_WAIT ticks (default 3). A write of 0x55 before the wait's last tick opens the window. A new 0xAA restarts the wait.
- R8: The window stays open for TA_OPEN ticks (default 3), then closes. Writes to bits 0 and 1 with the window closed are dropped. Opening the window again needs the full key.
- R9: Any key-register write other than those in R7 cancels the sequence and closes the window.
- R10: The control register is at CTRL_ADDR (default 0x40) and the key register at KEY_ADDR (default 0x41). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| tick | input | 1 | One-clock pulse per machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| tmo_sel | input | 2 | Timeout interval select |
| wd_ie | input | 1 | Watchdog interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| wd_rst | output | 1 | System reset pulse |
| wd_irq | output | 1 | Watchdog interrupt request |
| tmo_flag | output | 1 | Timeout flag |
| rst_cause | output | 1 | Watchdog-reset cause flag |
| wdt_rst_en | output | 1 | Current reset enable |

## Verification
The assertions check several rules on every cycle:
- A reset pulse never starts without the enable set, and always follows a set timeout flag.
- The pulse never runs longer than its length, and it always leaves the cause flag set.
- A guarded write with the window closed never moves the reset enable.
- The window opens only right after a 0x55 key write.

Only the bench scenarios can show the exact clock counts: the timeout of each select value, the grace delay and the pulse edges. They also show the window edges found by sweeping the ticks before and after the second key byte, the cancelling key values, and a last-moment restart that avoids the reset.

// File: rtl/wdt_guard_pkg.sv
`timescale 1ns/1ps
package wdt_guard_pkg;
    typedef enum logic [1:0] {KEY_IDLE, KEY_WAIT, KEY_OPEN} key_state_t;
    typedef enum logic [1:0] {DOG_RUN, DOG_ARMED, DOG_BITE} dog_state_t;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    // control register bit positions
    localparam int CB_RESTART = 0;
    localparam int CB_RSTEN   = 1;
    localparam int CB_FLAG    = 2;
    localparam int CB_CAUSE   = 3;
endpackage

// File: rtl/wdt_divider.sv
`timescale 1ns/1ps
module wdt_divider #(
    parameter int TAP_BASE = 17,
    parameter int TAP_STEP = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    localparam int NTAPS = 1 << SEL_W;
    localparam int CNT_W = TAP_BASE + (NTAPS - 1) * TAP_STEP;

    logic [CNT_W-1:0] cnt;
    logic [NTAPS-1:0] tap_full;

    // one all-ones detector per selectable interval
    generate
        for (genvar g = 0; g < NTAPS; g++) begin : g_tap
            localparam int TW = TAP_BASE + g * TAP_STEP;
            assign tap_full[g] = &cnt[TW-1:0];
        end
    endgenerate

    assign hit = tap_full[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_key_fsm.sv
`timescale 1ns/1ps
module wdt_key_fsm
    import wdt_guard_pkg::*;
#(
    parameter int TA_WAIT = 3,
    parameter int TA_OPEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       tick,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       win_open
);
    localparam int LIM = (TA_WAIT > TA_OPEN) ? TA_WAIT : TA_OPEN;
    localparam int CW  = $clog2(LIM + 1);

    key_state_t    st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (flush) begin
            st_nx  = KEY_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (st)
                KEY_IDLE: begin
                    cnt_nx = '0;
                    if (key_wr && key_data == KEY_FIRST) st_nx = KEY_WAIT;
                end
                KEY_WAIT: begin
                    if (key_wr) begin
                        cnt_nx = '0;
                        if (key_data == KEY_SECOND)     st_nx = KEY_OPEN;
                        else if (key_data == KEY_FIRST) st_nx = KEY_WAIT;
                        else                            st_nx = KEY_IDLE;
                    end else if (tick) begin
                        if (cnt == CW'(TA_WAIT - 1)) begin
                            st_nx  = KEY_IDLE;
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = cnt + 1'b1;
                        end
                    end
                end
                KEY_OPEN: begin
                    if (key_wr) begin
                        cnt_nx = '0;
                        st_nx  = (key_data == KEY_FIRST) ? KEY_WAIT : KEY_IDLE;
                    end else if (tick) begin
                        if (cnt == CW'(TA_OPEN - 1)) begin
                            st_nx  = KEY_IDLE;
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st_nx  = KEY_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= KEY_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        win_open = (st == KEY_OPEN);
    end
endmodule

// File: rtl/wdt_bite_fsm.sv
`timescale 1ns/1ps
module wdt_bite_fsm
    import wdt_guard_pkg::*;
#(
    parameter int RST_DELAY = 512,
    parameter int RST_CLKS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic restart,
    output logic bite,
    output logic enter_bite
);
    localparam int LIM = (RST_DELAY > RST_CLKS) ? RST_DELAY : RST_CLKS;
    localparam int CW  = $clog2(LIM + 1);

    dog_state_t    st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            DOG_RUN: begin
                cnt_nx = '0;
                if (arm) st_nx = DOG_ARMED;
            end
            DOG_ARMED: begin
                if (restart) begin
                    st_nx  = DOG_RUN;
                    cnt_nx = '0;
                end else if (cnt == CW'(RST_DELAY - 1)) begin
                    st_nx  = DOG_BITE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            DOG_BITE: begin
                if (cnt == CW'(RST_CLKS - 1)) begin
                    st_nx  = DOG_RUN;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                st_nx  = DOG_RUN;
                cnt_nx = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DOG_RUN;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        bite       = (st == DOG_BITE);
        enter_bite = (st == DOG_ARMED) && (st_nx == DOG_BITE);
    end
endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h41,
    parameter int                TAP_BASE  = 17,
    parameter int                TAP_STEP  = 3,
    parameter int                RST_DELAY = 512,
    parameter int                RST_CLKS  = 8,
    parameter int                TA_WAIT   = 3,
    parameter int                TA_OPEN   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        tmo_sel,
    input  logic              wd_ie,
    input  logic              glb_ie,
    output logic              wd_rst,
    output logic              wd_irq,
    output logic              tmo_flag,
    output logic              rst_cause,
    output logic              wdt_rst_en
);
    logic ctrl_wr, key_wr, win_open;
    logic restart_acc, div_clr, hit, hit_eff;
    logic bite, enter_bite;

    assign ctrl_wr     = wr_en && (wr_addr == CTRL_ADDR);
    assign key_wr      = wr_en && (wr_addr == KEY_ADDR);
    assign restart_acc = ctrl_wr && win_open && wr_data[CB_RESTART];
    assign div_clr     = restart_acc || bite;
    assign hit_eff     = hit && !div_clr;

    wdt_divider #(
        .TAP_BASE(TAP_BASE),
        .TAP_STEP(TAP_STEP),
        .SEL_W   (2)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (div_clr),
        .sel  (tmo_sel),
        .hit  (hit)
    );

    wdt_key_fsm #(
        .TA_WAIT(TA_WAIT),
        .TA_OPEN(TA_OPEN)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (bite),
        .tick    (tick),
        .key_wr  (key_wr),
        .key_data(wr_data),
        .win_open(win_open)
    );

    wdt_bite_fsm #(
        .RST_DELAY(RST_DELAY),
        .RST_CLKS (RST_CLKS)
    ) u_bite (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (hit_eff && wdt_rst_en),
        .restart   (restart_acc),
        .bite      (bite),
        .enter_bite(enter_bite)
    );

    // control and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_rst_en <= 1'b0;
            tmo_flag   <= 1'b0;
            rst_cause  <= 1'b0;
        end else begin
            if (enter_bite) begin
                tmo_flag  <= 1'b0;
                rst_cause <= 1'b1;
            end else begin
                if (hit_eff)                          tmo_flag  <= 1'b1;
                else if (ctrl_wr && !wr_data[CB_FLAG])  tmo_flag  <= 1'b0;
                if (ctrl_wr && !wr_data[CB_CAUSE])      rst_cause <= 1'b0;
            end
            if (ctrl_wr && win_open) wdt_rst_en <= wr_data[CB_RSTEN];
        end
    end

    assign wd_rst = bite;
    assign wd_irq = tmo_flag && wd_ie && glb_ie;
endmodule

// File: rtl/wdt_guard_chk.sv
`timescale 1ns/1ps
module wdt_guard_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h41,
    parameter int                RST_CLKS  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              wd_rst,
    input logic              tmo_flag,
    input logic              rst_cause,
    input logic              wdt_rst_en,
    input logic              win_open
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_cnt <= '0;
        else if (wd_rst) hi_cnt <= hi_cnt + 1'b1;
        else             hi_cnt <= '0;
    end

    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> wdt_rst_en);                                   // R5
    AST_FLAG_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> $past(tmo_flag));                              // R5
    AST_CAUSE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst) |-> rst_cause);                                    // R6
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> (hi_cnt < 16'(RST_CLKS)));                            // R6
    AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_ADDR && !win_open) |=> $stable(wdt_rst_en)); // R8
    AST_WIN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == 8'h55)); // R7
endmodule

bind wdt_guard wdt_guard_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .KEY_ADDR (KEY_ADDR),
    .RST_CLKS (RST_CLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wd_rst    (wd_rst),
    .tmo_flag  (tmo_flag),
    .rst_cause (rst_cause),
    .wdt_rst_en(wdt_rst_en),
    .win_open  (win_open)
);

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
    localparam int         TB_BASE  = 5;
    localparam int         TB_DELAY = 40;
    localparam int         TB_PULSE = 8;
    localparam logic [7:0] A_CTRL   = 8'h40;
    localparam logic [7:0] A_KEY    = 8'h41;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] tmo_sel = '0;
    logic       wd_ie = 1'b0;
    logic       glb_ie = 1'b0;
    logic       wd_rst, wd_irq, tmo_flag, rst_cause, wdt_rst_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    wdt_guard #(
        .ADDR_W   (8),
        .CTRL_ADDR(A_CTRL),
        .KEY_ADDR (A_KEY),
        .TAP_BASE (TB_BASE),
        .TAP_STEP (1),
        .RST_DELAY(TB_DELAY),
        .RST_CLKS (TB_PULSE),
        .TA_WAIT  (3),
        .TA_OPEN  (3)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tmo_sel   (tmo_sel),
        .wd_ie     (wd_ie),
        .glb_ie    (glb_ie),
        .wd_rst    (wd_rst),
        .wd_irq    (wd_irq),
        .tmo_flag  (tmo_flag),
        .rst_cause (rst_cause),
        .wdt_rst_en(wdt_rst_en)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        edge1();
        wr_en = 1'b0;
    endtask

    task automatic mc(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            edge1();
            tick = 1'b0;
            edge1(); edge1(); edge1();
        end
    endtask

    task automatic por();
        rst_n = 1'b0;
        edge1(); edge1();
        rst_n = 1'b1;
        edge1();
    endtask

    task automatic unlock();
        wr(A_KEY, 8'hAA);
        wr(A_KEY, 8'h55);
    endtask

    initial begin
        logic early;
        @(negedge clk);
        wd_ie = 1'b1; glb_ie = 1'b1;
        por();
        chk("R1 reset enable", wdt_rst_en, 0);
        chk("R1 flag", tmo_flag, 0);
        chk("R1 cause", rst_cause, 0);
        chk("R1 wd_rst", wd_rst, 0);
        chk("R1 irq", wd_irq, 0);

        // R3: restart with window closed is dropped (flag at divider 32 after por)
        tmo_sel = 2'd0;
        repeat (20) edge1();
        wr(A_CTRL, 8'h05);
        repeat (9) edge1();
        chk("R3 closed restart flag still 0", tmo_flag, 0);
        edge1();
        chk("R3 closed restart ignored, flag 1", tmo_flag, 1);

        // R2: each select value
        for (int s = 0; s < 4; s++) begin
            por();
            tmo_sel = 2'(s);
            unlock();
            wr(A_CTRL, 8'h01);
            repeat ((1 << (TB_BASE + s)) - 1) edge1();
            chk($sformatf("R2 sel %0d flag low", s), tmo_flag, 0);
            edge1();
            chk($sformatf("R2 sel %0d flag high", s), tmo_flag, 1);
        end

        // R4: interrupt gating and flag clear
        for (int k = 0; k < 4; k++) begin
            wd_ie = k[0]; glb_ie = k[1];
            edge1();
            chk($sformatf("R4 irq ie=%0d gie=%0d", k[0], k[1]), wd_irq, k[0] & k[1]);
        end
        wd_ie = 1'b1; glb_ie = 1'b1;
        wr(A_CTRL, 8'h08);
        chk("R4 flag cleared", tmo_flag, 0);
        chk("R4 irq low", wd_irq, 0);

        // R5/R6: delayed reset and its pulse
        por();
        tmo_sel = 2'd0;
        unlock();
        wr(A_CTRL, 8'h03);
        early = 1'b0;
        for (int k = 1; k < (1 << TB_BASE) + TB_DELAY; k++) begin
            edge1();
            if (wd_rst) early = 1'b1;
        end
        chk("R5 no early reset", early, 0);
        chk("R5 flag set during grace", tmo_flag, 1);
        edge1();
        chk("R5 reset after delay", wd_rst, 1);
        chk("R6 cause set", rst_cause, 1);
        chk("R6 enable kept", wdt_rst_en, 1);
        chk("R6 flag cleared", tmo_flag, 0);
        repeat (TB_PULSE - 1) edge1();
        chk("R6 pulse still high", wd_rst, 1);
        edge1();
        chk("R6 pulse ended", wd_rst, 0);
        repeat ((1 << TB_BASE) - 1) edge1();
        chk("R6 divider restarted low", tmo_flag, 0);
        edge1();
        chk("R6 divider restarted high", tmo_flag, 1);
        wr(A_CTRL, 8'h04);
        chk("R6 cause write-0 clear", rst_cause, 0);
        chk("R8 closed enable write dropped", wdt_rst_en, 1);

        // R5: last-moment restart avoids reset
        por();
        tmo_sel = 2'd0;
        unlock();
        wr(A_CTRL, 8'h07);
        repeat (1 << TB_BASE) edge1();
        chk("R5 armed flag", tmo_flag, 1);
        repeat (10) edge1();
        unlock();
        wr(A_CTRL, 8'h07);
        early = 1'b0;
        for (int k = 0; k < 70; k++) begin
            edge1();
            if (wd_rst) early = 1'b1;
        end
        chk("R5 restart prevents reset", early, 0);

        // R7/R8: window edges swept
        tmo_sel = 2'd3;
        for (int n = 0; n < 5; n++) begin
            for (int m = 0; m < 5; m++) begin
                por();
                wr(A_KEY, 8'hAA);
                mc(n);
                wr(A_KEY, 8'h55);
                mc(m);
                wr(A_CTRL, 8'h06);
                chk($sformatf("R7 R8 wait=%0d open=%0d", n, m), wdt_rst_en,
                    (n < 3 && m < 3) ? 1 : 0);
            end
        end

        // R9: wrong byte cancels
        por();
        wr(A_KEY, 8'hAA);
        wr(A_KEY, 8'h12);
        wr(A_KEY, 8'h55);
        wr(A_CTRL, 8'h06);
        chk("R9 cancelled key", wdt_rst_en, 0);
        // R7: second AA restarts the wait
        por();
        wr(A_KEY, 8'hAA);
        mc(2);
        wr(A_KEY, 8'hAA);
        mc(2);
        wr(A_KEY, 8'h55);
        wr(A_CTRL, 8'h06);
        chk("R7 repeated first byte restarts wait", wdt_rst_en, 1);

        // R10: other address has no effect
        por();
        unlock();
        wr(8'h42, 8'h06);
        chk("R10 foreign address ignored", wdt_rst_en, 0);
        wr(A_CTRL, 8'h06);
        chk("R10 control address accepted", wdt_rst_en, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule